// File: doc/BRIEF.md
# Per-Core Local Interrupt Unit

This block holds the private interrupt sources of every core in a cluster and decides, per core, which of them is presented to the processor. Seven sources exist per core, numbered 0 to 6 in a fixed order that is also the delivery priority: watchdog (0), compare (1), timer (2), performance counter (3), software interrupt A (4), software interrupt B (5) and debug channel (6). The five hardware sources arrive as live levels on input ports; the two software sources are bits held in a per-core register. Each core keeps a mask, a routable-control register and one routing register per source that steers the source onto one of a set of interrupt pins.

All registers sit behind one shared word-addressed bus. Every access names the requesting core. Address bit 4 picks the window: the local window reaches the requester's own registers, the other window reaches the core named in the requester's other-core select register. Per core, the block reports the index of the lowest-numbered source that is both pending and unmasked, and drives the pin vector built from the routing registers.

Top module: `lcl_irq_unit`

## Requirements
- R1: Per core, `irq_id` equals the lowest source index whose pending bit and mask bit are both 1, and equals 7 when no such bit exists; pending bits 0,1,2,3,6 follow `src_in` bits 0,1,2,3,6 of that core's 7-bit slice.
- R2: Writing offset 3 sets every mask bit written as 1, writing offset 4 clears every mask bit written as 1, other bits are kept; offset 2 reads the 7-bit mask.
- R3: Writing offset 5 loads data bits [1:0] into the software bits that form pending bits 4 and 5; `src_in` bits 4 and 5 have no effect.
- R4: Offset 8+s is the routing register of source s: bit 31 is the enable flag and the low pin-field bits the pin number; the pin is driven only while the flag is 1 and the source is pending and unmasked.
- R5: Offset 0 is the routable-control register (bit 0 timer, bit 1 performance counter, bit 2 both software sources, bit 3 debug channel); a source whose bit is 0 drives no pin while its `irq_id` priority is unchanged, and watchdog and compare are always routable.
- R6: Address bit 4 = 0 accesses the requesting core; bit 4 = 1 accesses the core held in the requester's select register, which is offset 6 and always belongs to the requester.
- R7: When the requester or the selected core index is not below NUM_CORES, writes change nothing and reads return 0.
- R8: After reset masks, software bits, routing flags, pin fields and select registers are 0, the control register is 0xF and `bus_rdata` is 0.
- R9: `bus_rdata` takes the addressed value on the clock edge that accepts a read and holds it otherwise; offset 1 reads the 7-bit pending vector.
- R10: A pin number not below NUM_PINS drives no pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_en | input | 1 | Access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_core | input | CORE_W | Requesting core |
| bus_addr | input | 5 | Window bit 4, register offset [3:0] |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| src_in | input | NUM_CORES*7 | Hardware source levels, 7 bits per core |
| irq_id | output | NUM_CORES*3 | Delivered source index per core, 7 = none |
| pin_out | output | NUM_CORES*NUM_PINS | Routed interrupt pins per core |

## Verification
The bench builds the block with three cores and six pins. Three cores make the select register two bits wide, so the value 3 names a core that does not exist and the out-of-range rule becomes testable, while a third core lets the other window reach a core other than the requester's neighbour. Six pins in a three-bit field leave codes 6 and 7 unused, exercising the rule that such pin numbers drive nothing.

// File: rtl/lcl_pkg.sv
// Shared constants and helpers of the local interrupt unit.
// Assumes a 32-bit bus and a fixed set of seven sources per core.
package lcl_pkg;
    localparam int NSRC   = 7;
    localparam int IDW    = 3;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 5;
    localparam int CTL_W  = 4;

    // source indices, also the delivery priority (low wins)
    localparam int SRC_WD   = 0;
    localparam int SRC_CMP  = 1;
    localparam int SRC_TMR  = 2;
    localparam int SRC_PERF = 3;
    localparam int SRC_SWA  = 4;
    localparam int SRC_SWB  = 5;
    localparam int SRC_DBG  = 6;

    // register offsets inside a window
    localparam logic [3:0] OFS_CTL  = 4'd0;
    localparam logic [3:0] OFS_PEND = 4'd1;
    localparam logic [3:0] OFS_MASK = 4'd2;
    localparam logic [3:0] OFS_MSET = 4'd3;
    localparam logic [3:0] OFS_MCLR = 4'd4;
    localparam logic [3:0] OFS_SWI  = 4'd5;
    localparam logic [3:0] OFS_SEL  = 4'd6;
    localparam int         OFS_MAP0 = 8;

    localparam int MAP_FLAG_BIT = 31;

    // Returns 1 when the control bits allow source s to reach a pin.
    function automatic logic src_routable(input logic [CTL_W-1:0] ctl, input int s);
        case (s)
            SRC_TMR:          return ctl[0];
            SRC_PERF:         return ctl[1];
            SRC_SWA, SRC_SWB: return ctl[2];
            SRC_DBG:          return ctl[3];
            default:          return 1'b1;
        endcase
    endfunction
endpackage

// File: rtl/lcl_core_regs.sv
// Register file of one core: mask, software bits, routable control,
// routing registers and the other-core select register.
// Assumes the parent has already decoded that this core is the target.
module lcl_core_regs
    import lcl_pkg::*;
#(
    parameter int PIN_W  = 3,
    parameter int CORE_W = 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [3:0]              wr_ofs,
    input  logic [DATA_W-1:0]       wr_data,
    input  logic                    sel_we,
    input  logic [CORE_W-1:0]       sel_data,
    output logic [NSRC-1:0]         mask_q,
    output logic [1:0]              sw_q,
    output logic [CTL_W-1:0]        ctl_q,
    output logic [NSRC-1:0]         flag_q,
    output logic [NSRC*PIN_W-1:0]   pin_q,
    output logic [CORE_W-1:0]       sel_q
);
    // Updates the per-core state from decoded bus writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            sw_q   <= '0;
            ctl_q  <= '1;
            flag_q <= '0;
            pin_q  <= '0;
            sel_q  <= '0;
        end else begin
            if (wr_en) begin
                case (wr_ofs)
                    OFS_CTL:  ctl_q  <= wr_data[CTL_W-1:0];
                    OFS_MSET: mask_q <= mask_q | wr_data[NSRC-1:0];
                    OFS_MCLR: mask_q <= mask_q & ~wr_data[NSRC-1:0];
                    OFS_SWI:  sw_q   <= wr_data[1:0];
                    default: ;
                endcase
                for (int s = 0; s < NSRC; s++) begin
                    if (wr_ofs == 4'(OFS_MAP0 + s)) begin
                        flag_q[s]                 <= wr_data[MAP_FLAG_BIT];
                        pin_q[s*PIN_W +: PIN_W]   <= wr_data[PIN_W-1:0];
                    end
                end
            end
            if (sel_we) sel_q <= sel_data;
        end
    end
endmodule

// File: rtl/lcl_prio.sv
// Lowest-index-first encoder; reports NSRC when no input bit is set.
// Assumes NSRC fits in IDW bits.
module lcl_prio
    import lcl_pkg::*;
(
    input  logic [NSRC-1:0] req,
    output logic [IDW-1:0]  id
);
    // Scans from the top so the lowest set bit is the last assignment.
    always_comb begin
        id = IDW'(NSRC);
        for (int s = NSRC - 1; s >= 0; s--) begin
            if (req[s]) id = IDW'(s);
        end
    end
endmodule

// File: rtl/lcl_router.sv
// Builds one core's pin vector from active sources and routing registers.
// Assumes pin numbers at or above NUM_PINS are simply unused.
module lcl_router
    import lcl_pkg::*;
#(
    parameter int NUM_PINS = 6,
    parameter int PIN_W    = 3
) (
    input  logic [NSRC-1:0]       active,
    input  logic [NSRC-1:0]       flag,
    input  logic [NSRC*PIN_W-1:0] pin,
    input  logic [CTL_W-1:0]      ctl,
    output logic [NUM_PINS-1:0]   pins
);
    // ORs every enabled, routable, active source onto its pin.
    always_comb begin
        pins = '0;
        for (int s = 0; s < NSRC; s++) begin
            if (active[s] && flag[s] && src_routable(ctl, s)) begin
                for (int p = 0; p < NUM_PINS; p++) begin
                    if (pin[s*PIN_W +: PIN_W] == PIN_W'(p)) pins[p] = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/lcl_irq_unit.sv
// Top of the per-core local interrupt unit: bus decode with local and
// other-core windows, per-core register files, priority and routing.
// Assumes one access per cycle on the shared bus.
module lcl_irq_unit
    import lcl_pkg::*;
#(
    parameter int NUM_CORES = 2,
    parameter int NUM_PINS  = 6,
    parameter int CORE_W    = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          bus_en,
    input  logic                          bus_we,
    input  logic [CORE_W-1:0]             bus_core,
    input  logic [ADDR_W-1:0]             bus_addr,
    input  logic [DATA_W-1:0]             bus_wdata,
    output logic [DATA_W-1:0]             bus_rdata,
    input  logic [NUM_CORES*NSRC-1:0]     src_in,
    output logic [NUM_CORES*IDW-1:0]      irq_id,
    output logic [NUM_CORES*NUM_PINS-1:0] pin_out
);
    localparam int PIN_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;

    logic [NSRC-1:0]       mask_a [NUM_CORES];
    logic [1:0]            sw_a   [NUM_CORES];
    logic [CTL_W-1:0]      ctl_a  [NUM_CORES];
    logic [NSRC-1:0]       flag_a [NUM_CORES];
    logic [NSRC*PIN_W-1:0] pin_a  [NUM_CORES];
    logic [CORE_W-1:0]     sel_a  [NUM_CORES];
    logic [NSRC-1:0]       pend_a [NUM_CORES];

    logic [3:0]        ofs;
    logic              req_ok;
    logic [CORE_W-1:0] sel_req;
    logic [CORE_W-1:0] tgt;
    logic              tgt_ok;
    logic [DATA_W-1:0] rd_val;

    assign ofs = bus_addr[3:0];

    // Resolves the requester's select value and the target core.
    always_comb begin
        req_ok  = (int'(bus_core) < NUM_CORES);
        sel_req = '0;
        for (int c = 0; c < NUM_CORES; c++) begin
            if (bus_core == CORE_W'(c)) sel_req = sel_a[c];
        end
        tgt    = bus_addr[4] ? sel_req : bus_core;
        tgt_ok = req_ok && (int'(tgt) < NUM_CORES);
    end

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
        logic wr_c;
        logic sel_we_c;

        assign wr_c     = bus_en && bus_we && tgt_ok && (tgt == CORE_W'(c)) && (ofs != OFS_SEL);
        assign sel_we_c = bus_en && bus_we && req_ok && (bus_core == CORE_W'(c)) && (ofs == OFS_SEL);

        lcl_core_regs #(.PIN_W(PIN_W), .CORE_W(CORE_W)) u_regs (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (wr_c),
            .wr_ofs   (ofs),
            .wr_data  (bus_wdata),
            .sel_we   (sel_we_c),
            .sel_data (bus_wdata[CORE_W-1:0]),
            .mask_q   (mask_a[c]),
            .sw_q     (sw_a[c]),
            .ctl_q    (ctl_a[c]),
            .flag_q   (flag_a[c]),
            .pin_q    (pin_a[c]),
            .sel_q    (sel_a[c])
        );

        assign pend_a[c] = {src_in[c*NSRC + SRC_DBG], sw_a[c],
                            src_in[c*NSRC +: SRC_SWA]};

        lcl_prio u_prio (
            .req (pend_a[c] & mask_a[c]),
            .id  (irq_id[c*IDW +: IDW])
        );

        lcl_router #(.NUM_PINS(NUM_PINS), .PIN_W(PIN_W)) u_route (
            .active (pend_a[c] & mask_a[c]),
            .flag   (flag_a[c]),
            .pin    (pin_a[c]),
            .ctl    (ctl_a[c]),
            .pins   (pin_out[c*NUM_PINS +: NUM_PINS])
        );
    end

    // Selects the read value of the addressed register.
    always_comb begin
        rd_val = '0;
        if (req_ok && ofs == OFS_SEL) rd_val = DATA_W'(sel_req);
        for (int c = 0; c < NUM_CORES; c++) begin
            if (tgt_ok && tgt == CORE_W'(c)) begin
                case (ofs)
                    OFS_CTL:  rd_val = DATA_W'(ctl_a[c]);
                    OFS_PEND: rd_val = DATA_W'(pend_a[c]);
                    OFS_MASK: rd_val = DATA_W'(mask_a[c]);
                    OFS_SWI:  rd_val = DATA_W'(sw_a[c]);
                    default: ;
                endcase
                for (int s = 0; s < NSRC; s++) begin
                    if (ofs == 4'(OFS_MAP0 + s)) begin
                        rd_val = DATA_W'(pin_a[c][s*PIN_W +: PIN_W]);
                        rd_val[MAP_FLAG_BIT] = flag_a[c][s];
                    end
                end
            end
        end
    end

    // Captures read data on an accepted read, holds it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)               bus_rdata <= '0;
        else if (bus_en && !bus_we) bus_rdata <= rd_val;
    end
endmodule

// File: rtl/lcl_irq_unit_chk.sv
// Property checker for lcl_irq_unit, attached by bind below.
// Assumes it sees the top's ports under their own names.
module lcl_irq_unit_chk
    import lcl_pkg::*;
#(
    parameter int NUM_CORES = 2,
    parameter int NUM_PINS  = 6,
    parameter int CORE_W    = 1
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          bus_en,
    input logic                          bus_we,
    input logic [CORE_W-1:0]             bus_core,
    input logic [ADDR_W-1:0]             bus_addr,
    input logic [DATA_W-1:0]             bus_wdata,
    input logic [DATA_W-1:0]             bus_rdata,
    input logic [NUM_CORES*NSRC-1:0]     src_in,
    input logic [NUM_CORES*IDW-1:0]      irq_id,
    input logic [NUM_CORES*NUM_PINS-1:0] pin_out
);
    AST_PINS_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (pin_out == '0)); // R8

    AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bus_en && !bus_we) |-> $stable(bus_rdata)); // R9

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_chk
        AST_MASK_CLEAR_SILENCES: assert property (@(posedge clk) disable iff (!rst_n)
            $past(bus_en && bus_we && bus_core == CORE_W'(c) &&
                  bus_addr == {1'b0, OFS_MCLR} && bus_wdata[NSRC-1:0] == '1)
            |-> (irq_id[c*IDW +: IDW] == IDW'(NSRC))); // R2

        AST_PIN_NEEDS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
            (|pin_out[c*NUM_PINS +: NUM_PINS]) |-> (irq_id[c*IDW +: IDW] != IDW'(NSRC))); // R4
    end
endmodule

bind lcl_irq_unit lcl_irq_unit_chk #(
    .NUM_CORES (NUM_CORES),
    .NUM_PINS  (NUM_PINS),
    .CORE_W    (CORE_W)
) u_chk (.*);

// File: tb/lcl_irq_unit_tb.sv
// Directed bench for lcl_irq_unit: three cores, six pins.
module lcl_irq_unit_tb;
    localparam int NC = 3;
    localparam int NP = 6;
    localparam int CW = 2;
    localparam int NS = 7;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            bus_en = 1'b0;
    logic            bus_we = 1'b0;
    logic [CW-1:0]   bus_core = '0;
    logic [4:0]      bus_addr = '0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic [NC*NS-1:0] src_in = '0;
    logic [NC*3-1:0] irq_id;
    logic [NC*NP-1:0] pin_out;

    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;

    lcl_irq_unit #(.NUM_CORES(NC), .NUM_PINS(NP), .CORE_W(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_core(bus_core), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .src_in(src_in), .irq_id(irq_id), .pin_out(pin_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int core, input bit other, input int ofs, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_core = CW'(core);
        bus_addr = {other, 4'(ofs)}; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input int core, input bit other, input int ofs, output logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_core = CW'(core);
        bus_addr = {other, 4'(ofs)};
        @(negedge clk);
        bus_en = 1'b0;
        d = bus_rdata;
    endtask

    function automatic logic [31:0] id_of(input int c);
        return 32'(irq_id[c*3 +: 3]);
    endfunction

    function automatic logic [31:0] pins_of(input int c);
        return 32'(pin_out[c*NP +: NP]);
    endfunction

    task automatic t_reset();
        logic [31:0] v;
        check("R8 rdata", bus_rdata, 0);
        for (int c = 0; c < NC; c++) check("R8 id", id_of(c), 7);
        check("R8 pins", 32'(pin_out), 0);
        rd(0, 0, 0, v);  check("R8 ctl", v, 32'hF);
        rd(1, 0, 2, v);  check("R8 mask", v, 0);
        rd(2, 0, 10, v); check("R8 map", v, 0);
        rd(1, 0, 6, v);  check("R8 sel", v, 0);
    endtask

    task automatic t_priority();
        logic [31:0] v;
        wr(0, 0, 3, 32'h7F);
        rd(0, 0, 2, v); check("R2 mask set", v, 32'h7F);
        src_in[0 +: NS] = 7'b100_1000; #1;
        check("R1 id 3", id_of(0), 3);
        src_in[0] = 1'b1; #1;
        check("R1 id 0", id_of(0), 0);
        src_in[0] = 1'b0;
        wr(0, 0, 4, 32'h08);
        check("R2 clear keeps others", id_of(0), 6);
        rd(0, 0, 2, v); check("R2 mask clr", v, 32'h77);
        src_in[0 +: NS] = '0; #1;
        check("R1 none", id_of(0), 7);
        wr(0, 0, 4, 32'h7F);
    endtask

    task automatic t_soft();
        logic [31:0] v;
        wr(1, 0, 3, 32'h7F);
        src_in[1*NS + 4] = 1'b1; #1;
        check("R3 input ignored", id_of(1), 7);
        wr(1, 0, 5, 32'h2);
        check("R3 sw b", id_of(1), 5);
        rd(1, 0, 1, v); check("R9 pend read", v, 32'h20);
        wr(1, 0, 5, 32'h0);
        check("R3 sw cleared", id_of(1), 7);
        src_in[1*NS + 4] = 1'b0;
        wr(1, 0, 4, 32'h7F);
    endtask

    task automatic t_route();
        logic [31:0] v;
        wr(0, 0, 3, 32'h7F);
        wr(0, 0, 8 + 2, 32'h8000_0004);
        rd(0, 0, 10, v); check("R4 map read", v, 32'h8000_0004);
        check("R9 rdata held after write", bus_rdata, 32'h8000_0004);
        src_in[2] = 1'b1; #1;
        check("R4 pin on", pins_of(0), 32'h10);
        wr(0, 0, 10, 32'h0000_0004);
        check("R4 flag off", pins_of(0), 0);
        wr(0, 0, 10, 32'h8000_0004);
        wr(0, 0, 4, 32'h04);
        check("R4 masked", pins_of(0), 0);
        wr(0, 0, 3, 32'h04);
        check("R4 pin back", pins_of(0), 32'h10);
    endtask

    task automatic t_routable();
        wr(0, 0, 0, 32'hE);
        check("R5 timer blocked", pins_of(0), 0);
        check("R5 id kept", id_of(0), 2);
        wr(0, 0, 8, 32'h8000_0001);
        wr(0, 0, 0, 32'h0);
        src_in[0] = 1'b1; #1;
        check("R5 watchdog routes", pins_of(0), 32'h02);
        src_in[0 +: NS] = '0;
        wr(0, 0, 0, 32'hF);
        wr(0, 0, 4, 32'h7F);
    endtask

    task automatic t_window();
        logic [31:0] v;
        wr(0, 0, 6, 32'd2);
        wr(0, 1, 3, 32'h01);
        rd(2, 0, 2, v); check("R6 other write", v, 32'h01);
        rd(0, 0, 2, v); check("R6 local untouched", v, 0);
        rd(0, 1, 6, v); check("R6 sel own", v, 2);
        rd(0, 1, 2, v); check("R6 other read", v, 32'h01);
        wr(2, 0, 4, 32'h7F);
    endtask

    task automatic t_sel_oob();
        logic [31:0] v;
        wr(0, 0, 6, 32'd3);
        wr(0, 1, 3, 32'h7F);
        for (int c = 0; c < NC; c++) begin
            rd(c, 0, 2, v); check("R7 no write", v, 0);
        end
        rd(0, 1, 0, v); check("R7 read zero", v, 0);
        wr(3, 0, 3, 32'h7F);
        rd(0, 0, 2, v); check("R7 bad requester", v, 0);
        wr(0, 0, 6, 32'd0);
    endtask

    task automatic t_pin_oob();
        wr(2, 0, 3, 32'h7F);
        wr(2, 0, 8 + 6, 32'h8000_0006);
        src_in[2*NS + 6] = 1'b1; #1;
        check("R10 pin 6", pins_of(2), 0);
        wr(2, 0, 14, 32'h8000_0007);
        check("R10 pin 7", pins_of(2), 0);
        wr(2, 0, 14, 32'h8000_0005);
        check("R10 pin 5 ok", pins_of(2), 32'h20);
        src_in = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_priority();
        t_soft();
        t_route();
        t_routable();
        t_window();
        t_sel_oob();
        t_pin_oob();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule